// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock Control

This block resolves read-after-write data hazards for a five-stage integer pipeline (fetch, decode, execute, memory, write-back). It compares the source register numbers of the instructions in decode and in execute against the destination, write-enable and load flags held in the three later pipe registers. From these comparisons it produces three results. The first is a mux select for each ALU operand. The second is a select for the store write-data path in the memory stage. The third is a set of hold and bubble controls for the PC, the fetch/decode register and the decode/execute register.

The register file writes in the first half of a cycle and reads in the second half. A producer three or more instructions ahead therefore needs no bypass, and only dependence distances of one and two are handled. A load followed directly by an instruction that uses the loaded value as an ALU operand or as an address base causes one stall cycle. During that cycle the PC and the fetch/decode register hold and the decode/execute register takes a bubble, which is all zeros and acts as a no-op. The consumer then picks the value up through the memory-to-execute path. A load whose value is the data of the store right behind it needs no stall. That value is steered in the memory stage through the store-data select, which the block registers one cycle ahead.

Destination numbers come from the decode logic upstream of this block. That logic uses rd for register-register ops and for jump-and-link-register, rt for immediate ALU ops and loads, and 31 for jump-and-link.

Top module: `hzd_bypass_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `st_data_sel` is 0 after that edge, whatever the other inputs are.
- R2: `fwd_a_sel` is 2'b01 (take the EX/MEM ALU result) when `xm_wen` is 1, `xm_load` is 0, `xm_dst` is nonzero and `xm_dst` equals `ex_rs`.
- R3: `fwd_a_sel` is 2'b10 (take the MEM/WB value) when the EX/MEM entry does not qualify under R2 and `mw_wen` is 1, `mw_dst` is nonzero and `mw_dst` equals `ex_rs`.
- R4: When both the EX/MEM and the MEM/WB entries qualify for the same source, the select is 2'b01, so the younger producer wins.
- R5: A source or destination of register 0, or a clear write-enable, never produces a match. With no match the select is 2'b00 (register file), and the value 2'b11 is never produced.
- R6: `fwd_b_sel` follows the rules of R2 to R5, applied to `ex_rt` in place of `ex_rs`.
- R7: An EX/MEM entry with `xm_load` set is never selected for either operand. The select falls through to MEM/WB or to the register file.
- R8: `pc_hold`, `ifid_hold` and `idex_bubble` are 1 when `de_load` and `de_wen` are 1, `de_dst` is nonzero, and either `id_rs_used` is 1 with `id_rs` equal to `de_dst`, or `id_rt_used` is 1 with `id_rt` equal to `de_dst`.
- R9: No stall is raised in four cases: the only match is on an rt that is not flagged as used in EX (store data), the producer in ID/EX is not a load, its destination is 0, or its write-enable is clear.
- R10: One clock edge after `ex_is_store` is 1 and `ex_rt` matches a nonzero `xm_dst` with `xm_wen` and `xm_load` both set, `st_data_sel` is 1 (take the MEM/WB load data). After any other edge out of reset it is 0.
- R11: `pc_hold`, `ifid_hold` and `idex_bubble` always carry the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the registered store-data select |
| rst_n | input | 1 | Synchronous active-low reset |
| id_rs | input | RW | rs number of the instruction in decode |
| id_rt | input | RW | rt number of the instruction in decode |
| id_rs_used | input | 1 | Decode instruction reads rs in EX (operand or base) |
| id_rt_used | input | 1 | Decode instruction reads rt as an ALU operand in EX |
| ex_rs | input | RW | rs number of the instruction in execute |
| ex_rt | input | RW | rt number of the instruction in execute |
| ex_is_store | input | 1 | Instruction in execute is a store |
| de_dst | input | RW | Destination held in ID/EX |
| de_wen | input | 1 | ID/EX instruction writes a register |
| de_load | input | 1 | ID/EX instruction is a load |
| xm_dst | input | RW | Destination held in EX/MEM |
| xm_wen | input | 1 | EX/MEM instruction writes a register |
| xm_load | input | 1 | EX/MEM instruction is a load |
| mw_dst | input | RW | Destination held in MEM/WB |
| mw_wen | input | 1 | MEM/WB instruction writes a register |
| fwd_a_sel | output | 2 | ALU A source: 00 register file, 01 EX/MEM, 10 MEM/WB |
| fwd_b_sel | output | 2 | ALU B / store-data source in EX, same encoding |
| st_data_sel | output | 1 | Store write data in MEM: 0 pipe value, 1 MEM/WB load data |
| pc_hold | output | 1 | Keep the PC unchanged this cycle |
| ifid_hold | output | 1 | Keep the IF/ID register unchanged this cycle |
| idex_bubble | output | 1 | Load all zeros into ID/EX this cycle |

## Verification
A load-use stall for the instruction in decode can fall in the same cycle as operand forwarding for the instruction in execute. The memory-to-memory store-data select can be active in that cycle as well. The stimulus table contains rows where a load in ID/EX matches a decode source while EX/MEM and MEM/WB also match execute sources. Each output is judged on its own rule, so a stall must not disturb the selects and the selects must not mask the stall. A directed sequence then holds a matching load and store in place across a clock edge and checks that the registered store-data select rises exactly one edge later. The same sequence checks that reset clears the select.

// File: rtl/hzd_pkg.sv
`timescale 1ns/1ps
// Shared types for the bypass and interlock control.
// Assumes the select encoding is consumed by operand muxes in EX.
package hzd_pkg;
    localparam int SEL_W = 2;

    typedef enum logic [SEL_W-1:0] {
        SRC_RF = 2'b00,
        SRC_XM = 2'b01,
        SRC_MW = 2'b10
    } fwd_src_e;
endpackage

// File: rtl/hzd_prod_hit.sv
`timescale 1ns/1ps
// Single producer/consumer comparator.
// Reports a hit when a qualified producer writes a nonzero register
// equal to the consumer's source number. Register 0 never matches.
module hzd_prod_hit #(
    parameter int RW = 5
) (
    input  logic [RW-1:0] src,
    input  logic [RW-1:0] dst,
    input  logic          wen,
    input  logic          allow,
    output logic          hit
);
    localparam logic [RW-1:0] REG_ZERO = '0;

    // Compare destination against source under the qualifiers.
    always_comb begin
        hit = allow && wen && (dst != REG_ZERO) && (dst == src);
    end
endmodule

// File: rtl/hzd_fwd_pick.sv
`timescale 1ns/1ps
// Operand source picker for one ALU input in EX.
// EX/MEM has priority over MEM/WB; an EX/MEM load is never a source,
// since its data only exists after MEM (interlock or store path covers it).
module hzd_fwd_pick
    import hzd_pkg::*;
#(
    parameter int RW = 5
) (
    input  logic [RW-1:0] src,
    input  logic [RW-1:0] xm_dst,
    input  logic          xm_wen,
    input  logic          xm_load,
    input  logic [RW-1:0] mw_dst,
    input  logic          mw_wen,
    output fwd_src_e      sel
);
    logic xm_hit;
    logic mw_hit;

    hzd_prod_hit #(.RW(RW)) u_xm (
        .src   (src),
        .dst   (xm_dst),
        .wen   (xm_wen),
        .allow (!xm_load),
        .hit   (xm_hit)
    );

    hzd_prod_hit #(.RW(RW)) u_mw (
        .src   (src),
        .dst   (mw_dst),
        .wen   (mw_wen),
        .allow (1'b1),
        .hit   (mw_hit)
    );

    // Priority select: younger producer first.
    always_comb begin
        if (xm_hit)      sel = SRC_XM;
        else if (mw_hit) sel = SRC_MW;
        else             sel = SRC_RF;
    end
endmodule

// File: rtl/hzd_loaduse.sv
`timescale 1ns/1ps
// Load-use detector for the instruction in decode.
// Raises stall when a load in ID/EX writes a register that a decode
// source consumes in EX. Sources flagged unused (store data) are ignored.
module hzd_loaduse #(
    parameter int RW   = 5,
    parameter int NSRC = 2
) (
    input  logic [NSRC-1:0][RW-1:0] srcs,
    input  logic [NSRC-1:0]         used,
    input  logic [RW-1:0]           de_dst,
    input  logic                    de_wen,
    input  logic                    de_load,
    output logic                    stall
);
    logic [NSRC-1:0] hits;

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        hzd_prod_hit #(.RW(RW)) u_cmp (
            .src   (srcs[g]),
            .dst   (de_dst),
            .wen   (de_wen),
            .allow (used[g] && de_load),
            .hit   (hits[g])
        );
    end

    // Any consuming source hit forces one stall cycle.
    always_comb begin
        stall = |hits;
    end
endmodule

// File: rtl/hzd_stfwd.sv
`timescale 1ns/1ps
// Store-data select for the MEM stage, decided one cycle early in EX.
// Assumes EX/MEM always advances (never stalled by this block), so the
// store in EX and the load in EX/MEM move together into MEM and MEM/WB.
module hzd_stfwd #(
    parameter int RW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ex_is_store,
    input  logic [RW-1:0] ex_rt,
    input  logic [RW-1:0] xm_dst,
    input  logic          xm_wen,
    input  logic          xm_load,
    output logic          st_sel
);
    logic pend_hit;
    logic st_q;

    hzd_prod_hit #(.RW(RW)) u_cmp (
        .src   (ex_rt),
        .dst   (xm_dst),
        .wen   (xm_wen),
        .allow (ex_is_store && xm_load),
        .hit   (pend_hit)
    );

    // Carry the decision along with the store into MEM.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= 1'b0;
        else        st_q <= pend_hit;
    end

    assign st_sel = st_q;
endmodule

// File: rtl/hzd_bypass_ctrl.sv
`timescale 1ns/1ps
// Data-hazard control for a five-stage pipeline.
// Produces ALU operand selects, a MEM-stage store-data select and the
// stall/bubble controls for PC, IF/ID and ID/EX. Destination numbers,
// write-enables and load flags are decoded upstream.
module hzd_bypass_ctrl
    import hzd_pkg::*;
#(
    parameter int RW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [RW-1:0] id_rs,
    input  logic [RW-1:0] id_rt,
    input  logic          id_rs_used,
    input  logic          id_rt_used,
    input  logic [RW-1:0] ex_rs,
    input  logic [RW-1:0] ex_rt,
    input  logic          ex_is_store,
    input  logic [RW-1:0] de_dst,
    input  logic          de_wen,
    input  logic          de_load,
    input  logic [RW-1:0] xm_dst,
    input  logic          xm_wen,
    input  logic          xm_load,
    input  logic [RW-1:0] mw_dst,
    input  logic          mw_wen,
    output logic [1:0]    fwd_a_sel,
    output logic [1:0]    fwd_b_sel,
    output logic          st_data_sel,
    output logic          pc_hold,
    output logic          ifid_hold,
    output logic          idex_bubble
);
    localparam int NOPS = 2;

    logic [NOPS-1:0][RW-1:0] ex_src;
    logic [NOPS-1:0][RW-1:0] id_src;
    logic [NOPS-1:0]         id_use;
    fwd_src_e                op_sel [NOPS];
    logic                    lu_stall;

    assign ex_src = {ex_rt, ex_rs};
    assign id_src = {id_rt, id_rs};
    assign id_use = {id_rt_used, id_rs_used};

    for (genvar g = 0; g < NOPS; g++) begin : g_op
        hzd_fwd_pick #(.RW(RW)) u_pick (
            .src     (ex_src[g]),
            .xm_dst  (xm_dst),
            .xm_wen  (xm_wen),
            .xm_load (xm_load),
            .mw_dst  (mw_dst),
            .mw_wen  (mw_wen),
            .sel     (op_sel[g])
        );
    end

    hzd_loaduse #(.RW(RW), .NSRC(NOPS)) u_lu (
        .srcs    (id_src),
        .used    (id_use),
        .de_dst  (de_dst),
        .de_wen  (de_wen),
        .de_load (de_load),
        .stall   (lu_stall)
    );

    hzd_stfwd #(.RW(RW)) u_st (
        .clk         (clk),
        .rst_n       (rst_n),
        .ex_is_store (ex_is_store),
        .ex_rt       (ex_rt),
        .xm_dst      (xm_dst),
        .xm_wen      (xm_wen),
        .xm_load     (xm_load),
        .st_sel      (st_data_sel)
    );

    // Drive operand selects and the shared stall controls.
    always_comb begin
        fwd_a_sel   = op_sel[0];
        fwd_b_sel   = op_sel[1];
        pc_hold     = lu_stall;
        ifid_hold   = lu_stall;
        idex_bubble = lu_stall;
    end
endmodule

// File: rtl/hzd_bypass_ctrl_chk.sv
`timescale 1ns/1ps
// Property checker for hzd_bypass_ctrl, attached by bind below.
module hzd_bypass_ctrl_chk #(
    parameter int RW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic [RW-1:0] id_rs,
    input logic          id_rs_used,
    input logic [RW-1:0] ex_rs,
    input logic [RW-1:0] ex_rt,
    input logic          ex_is_store,
    input logic [RW-1:0] de_dst,
    input logic          de_wen,
    input logic          de_load,
    input logic [RW-1:0] xm_dst,
    input logic          xm_wen,
    input logic          xm_load,
    input logic          mw_wen,
    input logic [1:0]    fwd_a_sel,
    input logic [1:0]    fwd_b_sel,
    input logic          st_data_sel,
    input logic          pc_hold
);
    localparam logic [RW-1:0] Z = '0;

    // R4
    younger_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xm_wen && !xm_load && xm_dst != Z && xm_dst == ex_rs) |-> fwd_a_sel == 2'b01);

    // R5
    zero_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_rs == Z) |-> fwd_a_sel == 2'b00);

    // R5
    legal_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_a_sel != 2'b11 && fwd_b_sel != 2'b11);

    // R7
    no_load_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xm_load && !mw_wen) |-> (fwd_a_sel != 2'b01 && fwd_b_sel != 2'b01));

    // R8
    load_use_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (de_load && de_wen && de_dst != Z && id_rs_used && id_rs == de_dst) |-> pc_hold);

    // R10
    st_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_data_sel |-> $past(ex_is_store && xm_load && ex_rt != Z));
endmodule

bind hzd_bypass_ctrl hzd_bypass_ctrl_chk #(.RW(RW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .id_rs       (id_rs),
    .id_rs_used  (id_rs_used),
    .ex_rs       (ex_rs),
    .ex_rt       (ex_rt),
    .ex_is_store (ex_is_store),
    .de_dst      (de_dst),
    .de_wen      (de_wen),
    .de_load     (de_load),
    .xm_dst      (xm_dst),
    .xm_wen      (xm_wen),
    .xm_load     (xm_load),
    .mw_wen      (mw_wen),
    .fwd_a_sel   (fwd_a_sel),
    .fwd_b_sel   (fwd_b_sel),
    .st_data_sel (st_data_sel),
    .pc_hold     (pc_hold)
);

// File: tb/hzd_bypass_ctrl_test.sv
`timescale 1ns/1ps
module hzd_bypass_ctrl_test;
    localparam int RW = 5;
    localparam int NV = 17;

    typedef struct packed {
        logic [3:0]    tag;
        logic [RW-1:0] id_rs, id_rt;
        logic          id_rs_used, id_rt_used;
        logic [RW-1:0] ex_rs, ex_rt, de_dst;
        logic          de_wen, de_load;
        logic [RW-1:0] xm_dst;
        logic          xm_wen, xm_load;
        logic [RW-1:0] mw_dst;
        logic          mw_wen;
        logic [1:0]    ea, eb;
        logic          est;
    } vec_t;

    function automatic vec_t mk(int tg, int irs, int irt, int iru, int itu,
                                int ers, int ert, int dd, int dw, int dl,
                                int xd, int xw, int xl, int md, int mwn,
                                int ea, int eb, int est);
        vec_t v;
        v.tag = 4'(tg);   v.id_rs = RW'(irs); v.id_rt = RW'(irt);
        v.id_rs_used = 1'(iru); v.id_rt_used = 1'(itu);
        v.ex_rs = RW'(ers); v.ex_rt = RW'(ert); v.de_dst = RW'(dd);
        v.de_wen = 1'(dw); v.de_load = 1'(dl);
        v.xm_dst = RW'(xd); v.xm_wen = 1'(xw); v.xm_load = 1'(xl);
        v.mw_dst = RW'(md); v.mw_wen = 1'(mwn);
        v.ea = 2'(ea); v.eb = 2'(eb); v.est = 1'(est);
        return v;
    endfunction

    //                 tag irs irt iru itu ers ert dd dw dl xd xw xl md mw  ea eb st
    localparam vec_t VECS [NV] = '{
        mk(5,  0, 0, 0, 0,  0, 0, 0, 0, 0,  0, 0, 0,  0, 0,  0, 0, 0), // R5 idle
        mk(2,  0, 0, 0, 0,  3, 4, 0, 0, 0,  3, 1, 0,  0, 0,  1, 0, 0), // R2 EX/MEM to A
        mk(3,  0, 0, 0, 0,  3, 4, 0, 0, 0,  0, 0, 0,  3, 1,  2, 0, 0), // R3 MEM/WB to A
        mk(4,  0, 0, 0, 0,  3, 3, 0, 0, 0,  3, 1, 0,  3, 1,  1, 1, 0), // R4 both match
        mk(6,  0, 0, 0, 0,  8, 7, 0, 0, 0,  7, 1, 0,  8, 1,  2, 1, 0), // R6 B from EX/MEM
        mk(6,  0, 0, 0, 0,  1, 9, 0, 0, 0,  2, 1, 0,  9, 1,  0, 2, 0), // R6 B from MEM/WB
        mk(5,  0, 0, 0, 0,  0, 0, 0, 0, 0,  0, 1, 0,  0, 1,  0, 0, 0), // R5 reg 0
        mk(5,  0, 0, 0, 0,  6, 6, 0, 0, 0,  6, 0, 0,  6, 0,  0, 0, 0), // R5 wen clear
        mk(7,  0, 0, 0, 0,  5, 1, 0, 0, 0,  5, 1, 1,  5, 1,  2, 0, 0), // R7 falls to MEM/WB
        mk(7,  0, 0, 0, 0,  2, 5, 0, 0, 0,  5, 1, 1,  0, 0,  0, 0, 0), // R7 falls to RF
        mk(8,  4, 1, 1, 0,  0, 0, 4, 1, 1,  0, 0, 0,  0, 0,  0, 0, 1), // R8 rs use
        mk(8,  1, 4, 1, 1,  0, 0, 4, 1, 1,  0, 0, 0,  0, 0,  0, 0, 1), // R8 rt use
        mk(8,  4, 2, 1, 0,  3, 6, 4, 1, 1,  3, 1, 0,  6, 1,  1, 2, 1), // R8 stall with forwards
        mk(9,  1, 4, 1, 0,  0, 0, 4, 1, 1,  0, 0, 0,  0, 0,  0, 0, 0), // R9 store data only
        mk(9,  4, 0, 1, 0,  0, 0, 4, 1, 0,  0, 0, 0,  0, 0,  0, 0, 0), // R9 not a load
        mk(9,  0, 0, 1, 1,  0, 0, 0, 1, 1,  0, 0, 0,  0, 0,  0, 0, 0), // R9 dst zero
        mk(9,  4, 4, 1, 1,  0, 0, 4, 0, 1,  0, 0, 0,  0, 0,  0, 0, 0)  // R9 wen clear
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic [RW-1:0] id_rs, id_rt, ex_rs, ex_rt, de_dst, xm_dst, mw_dst;
    logic          id_rs_used, id_rt_used, ex_is_store, de_wen, de_load;
    logic          xm_wen, xm_load, mw_wen;
    logic [1:0]    fwd_a_sel, fwd_b_sel;
    logic          st_data_sel, pc_hold, ifid_hold, idex_bubble;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    hzd_bypass_ctrl #(.RW(RW)) uut (
        .clk(clk), .rst_n(rst_n),
        .id_rs(id_rs), .id_rt(id_rt), .id_rs_used(id_rs_used), .id_rt_used(id_rt_used),
        .ex_rs(ex_rs), .ex_rt(ex_rt), .ex_is_store(ex_is_store),
        .de_dst(de_dst), .de_wen(de_wen), .de_load(de_load),
        .xm_dst(xm_dst), .xm_wen(xm_wen), .xm_load(xm_load),
        .mw_dst(mw_dst), .mw_wen(mw_wen),
        .fwd_a_sel(fwd_a_sel), .fwd_b_sel(fwd_b_sel), .st_data_sel(st_data_sel),
        .pc_hold(pc_hold), .ifid_hold(ifid_hold), .idex_bubble(idex_bubble)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        id_rs = v.id_rs; id_rt = v.id_rt;
        id_rs_used = v.id_rs_used; id_rt_used = v.id_rt_used;
        ex_rs = v.ex_rs; ex_rt = v.ex_rt;
        de_dst = v.de_dst; de_wen = v.de_wen; de_load = v.de_load;
        xm_dst = v.xm_dst; xm_wen = v.xm_wen; xm_load = v.xm_load;
        mw_dst = v.mw_dst; mw_wen = v.mw_wen;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            finish_run();
        end
    end

    initial begin
        rst_n = 1'b0;
        ex_is_store = 1'b1;
        apply(mk(0, 0, 0, 0, 0, 0, 4, 0, 0, 0, 4, 1, 1, 0, 0, 0, 0, 0));
        // R1: matching store/load pair held during reset must not set the select
        @(posedge clk); @(posedge clk); #1;
        chk(st_data_sel == 1'b0, "R1", st_data_sel, 0);

        // R10: release reset; the next edge registers the pending match
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #1;
        chk(st_data_sel == 1'b1, "R10", st_data_sel, 1);
        @(negedge clk) xm_load = 1'b0;          // producer is not a load
        @(posedge clk); #1;
        chk(st_data_sel == 1'b0, "R10", st_data_sel, 0);
        @(negedge clk) begin xm_load = 1'b1; ex_rt = '0; xm_dst = '0; end
        @(posedge clk); #1;
        chk(st_data_sel == 1'b0, "R10", st_data_sel, 0);
        @(negedge clk) begin ex_rt = 5'd4; xm_dst = 5'd4; ex_is_store = 1'b0; end
        @(posedge clk); #1;
        chk(st_data_sel == 1'b0, "R10", st_data_sel, 0);
        @(negedge clk) ex_is_store = 1'b1;
        @(posedge clk); #1;
        chk(st_data_sel == 1'b1, "R10", st_data_sel, 1);
        @(negedge clk) rst_n = 1'b0;
        @(posedge clk); #1;
        chk(st_data_sel == 1'b0, "R1", st_data_sel, 0);
        @(negedge clk) begin rst_n = 1'b1; ex_is_store = 1'b0; end

        // Table walk: combinational selects and stall controls
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            apply(VECS[i]);
            #1;
            chk(fwd_a_sel == VECS[i].ea, $sformatf("R%0d A sel row %0d", VECS[i].tag, i),
                fwd_a_sel, VECS[i].ea);
            chk(fwd_b_sel == VECS[i].eb, $sformatf("R%0d B sel row %0d", VECS[i].tag, i),
                fwd_b_sel, VECS[i].eb);
            chk(pc_hold == VECS[i].est, $sformatf("R%0d stall row %0d", VECS[i].tag, i),
                pc_hold, VECS[i].est);
            // R11: the three controls agree
            chk(ifid_hold == pc_hold && idex_bubble == pc_hold, "R11",
                {ifid_hold, idex_bubble}, {pc_hold, pc_hold});
            chk(st_data_sel == 1'b0, "R10 no store", st_data_sel, 0);
        end

        // R8 exactly one stall: after the bubble ID/EX is empty and the consumer is released
        @(negedge clk);
        apply(mk(8, 4, 0, 1, 0, 4, 0, 0, 0, 0, 4, 1, 1, 0, 0, 0, 0, 0));
        #1;
        chk(pc_hold == 1'b0, "R8 bubble releases", pc_hold, 0);
        @(negedge clk);
        apply(mk(3, 4, 0, 1, 0, 4, 0, 0, 0, 0, 0, 0, 0, 4, 1, 0, 0, 0));
        #1;
        chk(fwd_a_sel == 2'b10, "R3 load data after stall", fwd_a_sel, 2);

        done = 1'b1;
        finish_run();
    end
endmodule